// File: doc/BRIEF.md
# PS/2 Mouse Host-Command Error Handler

This block sits between a mouse's serial byte receiver, its byte transmitter and its motion accumulators. Each byte the host sends is classified in a single cycle. A byte with a parity or framing error, or a code the command table does not know, is rejected. A Resend request replays the most recently sent packet. Any other recognised command is passed on to the command executor, and the motion accumulators are cleared at the same moment.

Rejections escalate. A lone bad byte gets the resend code, and a second bad byte straight after it gets the error code. The block keeps a small store holding the last packet of one to three bytes and feeds the transmitter through a request/accept handshake. A deadline timer flags a reply that the transmitter has not begun to take in time.

Top module: `ms_cmd_guard`

## Requirements
- R1: An accepted byte that has `rx_perr` high, or that is not 0xFE and has `cmd_known` low, is invalid. When the previous accepted byte was valid (or none has been accepted since reset), the cycle after acceptance shows `tx_req` high with `tx_byte` = 0xFE. This holds for a corrupted 0xFE as well. The byte 0xFE without an error is always recognised.
- R2: An invalid byte that directly follows another invalid byte is answered with the single byte 0xFC. The invalid streak then restarts, so a third invalid byte in a row is answered with 0xFE again.
- R3: Any accepted valid byte (a Resend or a command) ends the invalid streak. An invalid byte after it is answered with 0xFE.
- R4: An accepted valid byte other than 0xFE raises `cnt_clr` and `cmd_fwd` for exactly the following cycle, with `cmd_fwd_byte` equal to that byte. The block queues no reply of its own for it.
- R5: An accepted valid 0xFE replays the stored packet in the order byte 0 (`pkt_data[7:0]`), byte 1 (`[15:8]`), byte 2 (`[23:16]`), sending as many bytes as were stored (1 to 3). It raises neither `cnt_clr` nor `cmd_fwd`.
- R6: A Resend accepted before any packet has been stored produces no reply.
- R7: An invalid byte raises neither `cnt_clr` nor `cmd_fwd`.
- R8: `tx_byte` is held while `tx_req` is high and `tx_ack` is low. After an accepted byte, the next byte of a reply is offered in the following cycle, and `tx_req` falls after the last byte.
- R9: A byte that arrives while a reply is still pending (`tx_req` high) is ignored. It has no clear, no forward and no extra reply byte.
- R10: `resp_late` pulses for one cycle when RESP_DEADLINE cycles pass after a reply is queued and its first byte has not been accepted. It stays low if the first byte is accepted sooner.
- R11: After reset, `tx_req`, `cnt_clr`, `cmd_fwd` and `resp_late` are low, the invalid streak is zero and the packet store is empty.
- R12: A `pkt_wr` with `pkt_len` = 0 (or above PKT_MAX) leaves the stored packet unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a host byte has been received |
| rx_byte | input | 8 | Received host byte |
| rx_perr | input | 1 | Parity or framing error on this byte |
| cmd_known | input | 1 | Command-table lookup result for `rx_byte` |
| pkt_wr | input | 1 | Records the packet just sent to the host |
| pkt_len | input | 2 | Byte count of that packet (1 to 3) |
| pkt_data | input | 24 | Packet bytes, byte 0 in the low octet |
| tx_ack | input | 1 | Transmitter takes `tx_byte` this cycle |
| tx_req | output | 1 | A reply byte is offered |
| tx_byte | output | 8 | Offered reply byte |
| cnt_clr | output | 1 | One-cycle clear of the motion accumulators |
| cmd_fwd | output | 1 | One-cycle strobe: a command goes to the executor |
| cmd_fwd_byte | output | 8 | The forwarded command byte |
| resp_late | output | 1 | One-cycle pulse: reply deadline missed |

## Verification
The assertions assume that the host presents `rx_valid` for one cycle per byte. They also assume that `cmd_known` is settled in that same cycle and that `tx_ack` is only meaningful while `tx_req` is high. The bench keeps to these assumptions: every input is driven on the falling clock edge, each byte strobe lasts exactly one cycle, and the acknowledge is raised only when replies are being drained. It deliberately strobes a byte while a reply is pending, so that the ignore path is exercised rather than assumed away.

// File: rtl/ms_guard_pkg.sv
package ms_guard_pkg;

  localparam logic [7:0] CODE_RESEND = 8'hFE;
  localparam logic [7:0] CODE_ERROR  = 8'hFC;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_INVALID = 2'd1,
    EV_REPLAY  = 2'd2,
    EV_CMD     = 2'd3
  } ev_e;

  // Classify one received host byte; error wins over everything.
  function automatic ev_e classify(input logic perr, input logic known,
                                   input logic [7:0] b);
    if (perr) return EV_INVALID;
    if (b == CODE_RESEND) return EV_REPLAY;
    if (!known) return EV_INVALID;
    return EV_CMD;
  endfunction

  // Reply to a rejected byte, depending on whether the streak escalates.
  function automatic logic [7:0] err_reply(input logic escalate);
    return escalate ? CODE_ERROR : CODE_RESEND;
  endfunction

endpackage

// File: rtl/ms_err_track.sv
module ms_err_track #(
  parameter int INV_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inv_ev,
  input  logic ok_ev,
  output logic escalate
);
  localparam int CW = $clog2(INV_LIMIT + 1);

  logic [CW-1:0] streak;

  assign escalate = inv_ev && (streak == CW'(INV_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak <= '0;
    end else if (ok_ev) begin
      streak <= '0;
    end else if (inv_ev) begin
      streak <= escalate ? '0 : streak + CW'(1);
    end
  end

  generate
    if (INV_LIMIT > 1) begin : g_chk
      // R3: a valid byte leaves no streak behind for the next one
      a_r3_streak_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ok_ev |=> (inv_ev |-> !escalate));
      // R2: escalation restarts the streak
      a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        escalate |=> (inv_ev |-> !escalate));
    end
  endgenerate

endmodule

// File: rtl/ms_pkt_store.sv
module ms_pkt_store #(
  parameter int PKT_MAX = 3,
  localparam int LW = $clog2(PKT_MAX + 1),
  localparam int DW = 8 * PKT_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [LW-1:0] wr_len,
  input  logic [DW-1:0] wr_data,
  output logic [LW-1:0] st_len,
  output logic [DW-1:0] st_data
);
  logic take;
  assign take = wr && (wr_len != '0) && (int'(wr_len) <= PKT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_len  <= '0;
      st_data <= '0;
    end else if (take) begin
      st_len  <= wr_len;
      st_data <= wr_data;
    end
  end

  // R12: a write with an out-of-range length changes nothing
  a_r12_len_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_len == '0) |=> $stable(st_len) && $stable(st_data));

endmodule

// File: rtl/ms_resp_seq.sv
module ms_resp_seq #(
  parameter int PKT_MAX = 3,
  parameter int RESP_DEADLINE = 16,
  localparam int LW = $clog2(PKT_MAX + 1),
  localparam int DW = 8 * PKT_MAX,
  localparam int TW = $clog2(RESP_DEADLINE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] start_len,
  input  logic [DW-1:0] start_data,
  input  logic          tx_ack,
  output logic          busy,
  output logic [7:0]    tx_byte,
  output logic          late
);
  logic [DW-1:0] q_data;
  logic [LW-1:0] q_len;
  logic [LW-1:0] q_idx;
  logic [TW-1:0] timer;
  logic          tmr_run;
  logic          last_byte;
  logic          deadline_hit;

  assign tx_byte      = q_data[8*q_idx +: 8];
  assign last_byte    = (q_idx == q_len - LW'(1));
  assign deadline_hit = tmr_run && !tx_ack && (timer == TW'(RESP_DEADLINE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      q_data  <= '0;
      q_len   <= '0;
      q_idx   <= '0;
      timer   <= '0;
      tmr_run <= 1'b0;
      late    <= 1'b0;
    end else begin
      late <= 1'b0;
      if (start && start_len != '0) begin
        busy    <= 1'b1;
        q_data  <= start_data;
        q_len   <= start_len;
        q_idx   <= '0;
        timer   <= '0;
        tmr_run <= 1'b1;
      end else if (busy) begin
        if (tx_ack) begin
          tmr_run <= 1'b0;
          if (last_byte) busy <= 1'b0;
          else q_idx <= q_idx + LW'(1);
        end else if (deadline_hit) begin
          late    <= 1'b1;
          tmr_run <= 1'b0;
        end else if (tmr_run) begin
          timer <= timer + TW'(1);
        end
      end
    end
  end

  // R8: an offered byte is held until taken
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_ack) |=> busy && $stable(tx_byte));
  // R10: the late flag is a single-cycle pulse
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    late |=> !late);
  // R10: no late flag once the first byte has gone
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_ack && !start) |=> !late);

endmodule

// File: rtl/ms_cmd_guard.sv
module ms_cmd_guard #(
  parameter int PKT_MAX       = 3,
  parameter int INV_LIMIT     = 2,
  parameter int RESP_DEADLINE = 2500000,
  localparam int LW = $clog2(PKT_MAX + 1),
  localparam int DW = 8 * PKT_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_perr,
  input  logic          cmd_known,
  input  logic          pkt_wr,
  input  logic [LW-1:0] pkt_len,
  input  logic [DW-1:0] pkt_data,
  input  logic          tx_ack,
  output logic          tx_req,
  output logic [7:0]    tx_byte,
  output logic          cnt_clr,
  output logic          cmd_fwd,
  output logic [7:0]    cmd_fwd_byte,
  output logic          resp_late
);
  import ms_guard_pkg::*;

  logic          seq_busy;
  logic          accept;
  ev_e           ev;
  logic          ev_inv, ev_replay, ev_cmd;
  logic          escalate;
  logic [LW-1:0] st_len;
  logic [DW-1:0] st_data;
  logic          q_start;
  logic [LW-1:0] q_len;
  logic [DW-1:0] q_data;

  assign accept    = rx_valid && !seq_busy;
  assign ev        = accept ? classify(rx_perr, cmd_known, rx_byte) : EV_NONE;
  assign ev_inv    = (ev == EV_INVALID);
  assign ev_replay = (ev == EV_REPLAY);
  assign ev_cmd    = (ev == EV_CMD);

  assign q_start = ev_inv || ev_replay;
  assign q_len   = ev_inv ? LW'(1) : st_len;
  assign q_data  = ev_inv ? DW'(err_reply(escalate)) : st_data;

  ms_err_track #(.INV_LIMIT(INV_LIMIT)) u_track (
    .clk(clk), .rst_n(rst_n),
    .inv_ev(ev_inv), .ok_ev(ev_replay || ev_cmd),
    .escalate(escalate)
  );

  ms_pkt_store #(.PKT_MAX(PKT_MAX)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr(pkt_wr), .wr_len(pkt_len), .wr_data(pkt_data),
    .st_len(st_len), .st_data(st_data)
  );

  ms_resp_seq #(.PKT_MAX(PKT_MAX), .RESP_DEADLINE(RESP_DEADLINE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(q_start), .start_len(q_len), .start_data(q_data),
    .tx_ack(tx_ack), .busy(seq_busy), .tx_byte(tx_byte), .late(resp_late)
  );

  assign tx_req = seq_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_clr      <= 1'b0;
      cmd_fwd      <= 1'b0;
      cmd_fwd_byte <= '0;
    end else begin
      cnt_clr <= ev_cmd;
      cmd_fwd <= ev_cmd;
      if (ev_cmd) cmd_fwd_byte <= rx_byte;
    end
  end

  // R1: a lone bad byte draws the resend code
  a_r1_resend_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inv && !escalate) |=> tx_req && tx_byte == CODE_RESEND);
  // R2: a repeated bad byte draws the error code
  a_r2_error_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inv && escalate) |=> tx_req && tx_byte == CODE_ERROR);
  // R4: commands clear the accumulators
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd |=> cnt_clr && cmd_fwd && !tx_req);
  // R5: replay leaves the accumulators alone
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ev_replay |=> !cnt_clr && !cmd_fwd);
  // R7: rejected bytes clear nothing
  a_r7_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv |=> !cnt_clr && !cmd_fwd);
  // R9: bytes during a pending reply have no effect
  a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && tx_req) |=> !cnt_clr && !cmd_fwd);

endmodule

// File: tb/ms_cmd_guard_tb.sv
module ms_cmd_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_perr = 1'b0;
  logic        cmd_known = 1'b0;
  logic        pkt_wr = 1'b0;
  logic [1:0]  pkt_len = '0;
  logic [23:0] pkt_data = '0;
  logic        tx_ack = 1'b0;
  logic        tx_req, cnt_clr, cmd_fwd, resp_late;
  logic [7:0]  tx_byte, cmd_fwd_byte;

  int total = 0;
  int bad = 0;
  logic [7:0] got [4];
  int got_n;

  always #2.5 clk = ~clk;

  ms_cmd_guard #(.RESP_DEADLINE(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .cmd_known(cmd_known), .pkt_wr(pkt_wr),
    .pkt_len(pkt_len), .pkt_data(pkt_data), .tx_ack(tx_ack),
    .tx_req(tx_req), .tx_byte(tx_byte), .cnt_clr(cnt_clr),
    .cmd_fwd(cmd_fwd), .cmd_fwd_byte(cmd_fwd_byte), .resp_late(resp_late)
  );

  // {perr, known, byte, exp_req, exp_byte, exp_clr}
  localparam logic [19:0] VEC [8] = '{
    {1'b1, 1'b1, 8'h20, 1'b1, 8'hFE, 1'b0},  // R1 parity error
    {1'b0, 1'b1, 8'hE6, 1'b0, 8'h00, 1'b1},  // R4 command, R3 streak end
    {1'b0, 1'b0, 8'h55, 1'b1, 8'hFE, 1'b0},  // R1 unknown code
    {1'b0, 1'b0, 8'h66, 1'b1, 8'hFC, 1'b0},  // R2 second in a row
    {1'b0, 1'b0, 8'h77, 1'b1, 8'hFE, 1'b0},  // R2 streak restarted
    {1'b0, 1'b1, 8'hF4, 1'b0, 8'h00, 1'b1},  // R4 command
    {1'b1, 1'b1, 8'hFE, 1'b1, 8'hFE, 1'b0},  // R1 corrupted resend
    {1'b1, 1'b0, 8'h10, 1'b1, 8'hFC, 1'b0}   // R2 escalation
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic perr, input logic known, input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_perr = perr; cmd_known = known; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; cmd_known = 1'b0;
  endtask

  task automatic drain();
    got_n = 0;
    tx_ack = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (tx_req && got_n < 4) begin
        got[got_n] = tx_byte;
        got_n++;
      end
      @(negedge clk);
    end
    tx_ack = 1'b0;
  endtask

  task automatic store(input logic [1:0] n, input logic [23:0] d);
    @(negedge clk);
    pkt_wr = 1'b1; pkt_len = n; pkt_data = d;
    @(negedge clk);
    pkt_wr = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lates;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 tx_req", tx_req, 0);
    chk("R11 cnt_clr", cnt_clr, 0);
    chk("R11 cmd_fwd", cmd_fwd, 0);
    chk("R11 resp_late", resp_late, 0);

    // R6: resend with nothing stored
    send(1'b0, 1'b1, 8'hFE);
    chk("R6 no reply", tx_req, 0);
    drain();
    chk("R6 no bytes", got_n, 0);

    for (int v = 0; v < 8; v++) begin
      logic [19:0] e;
      e = VEC[v];
      send(e[19], e[18], e[17:10]);
      chk($sformatf("R1/R2 req v%0d", v), tx_req, e[9]);
      if (e[9]) chk($sformatf("R1/R2 byte v%0d", v), tx_byte, e[8:1]);
      chk($sformatf("R4/R7 clr v%0d", v), cnt_clr, e[0]);
      chk($sformatf("R4/R7 fwd v%0d", v), cmd_fwd, e[0]);
      if (e[0]) chk($sformatf("R4 fwd byte v%0d", v), cmd_fwd_byte, e[17:10]);
      drain();
      chk($sformatf("R8 count v%0d", v), got_n, e[9] ? 1 : 0);
    end

    // R5: three-byte replay in order, no clear
    store(2'd3, 24'h341208);
    send(1'b0, 1'b0, 8'hFE);
    chk("R5 clr", cnt_clr, 0);
    chk("R5 fwd", cmd_fwd, 0);
    repeat (2) @(negedge clk);
    chk("R8 held", tx_byte, 8'h08);
    drain();
    chk("R5 count3", got_n, 3);
    chk("R5 b0", got[0], 8'h08);
    chk("R5 b1", got[1], 8'h12);
    chk("R5 b2", got[2], 8'h34);
    chk("R8 req falls", tx_req, 0);

    // R3: the valid resend ended the streak
    send(1'b0, 1'b0, 8'h99);
    chk("R3 after resend", tx_byte, 8'hFE);
    drain();

    // R5 single byte, R12 zero-length write ignored
    store(2'd1, 24'h0000FA);
    store(2'd0, 24'h777777);
    send(1'b0, 1'b0, 8'hFE);
    drain();
    chk("R12 count", got_n, 1);
    chk("R12 byte", got[0], 8'hFA);

    // R9: command during pending reply is ignored
    send(1'b0, 1'b0, 8'h42);
    send(1'b0, 1'b1, 8'hF4);
    chk("R9 clr", cnt_clr, 0);
    chk("R9 fwd", cmd_fwd, 0);
    drain();
    chk("R9 count", got_n, 1);
    chk("R9 byte", got[0], 8'hFE);

    // R10: deadline missed
    send(1'b0, 1'b1, 8'hF4);
    send(1'b0, 1'b0, 8'h31);
    lates = 0;
    for (int i = 0; i < 20; i++) begin
      if (resp_late) lates++;
      @(negedge clk);
    end
    chk("R10 one pulse", lates, 1);
    drain();

    // R10: first byte taken in time
    send(1'b0, 1'b0, 8'h32);
    tx_ack = 1'b1;
    lates = 0;
    for (int i = 0; i < 20; i++) begin
      if (resp_late) lates++;
      @(negedge clk);
    end
    tx_ack = 1'b0;
    chk("R10 no pulse", lates, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule